// File: doc/BRIEF.md
# MMU Control and Status Register Front End

This block is the software-visible control face of a page-table memory management unit. It sits on a simple 32-bit word-addressed register bus. Through this bus, software sets the page directory base, issues commands, and reads status, interrupt and fault-capture information. The table walker and the translation cache live elsewhere. The walker reports faults, bus errors and its idle state to this block. In return, the block drives a stall request, a one-cycle flush strobe, a paging-enable level and a fault-hold level back to the walker.

All control actions go through one command register. Depending on the value written, a command turns paging on, raises or drops the stall request, flushes cached translations, or performs a hard reset of the unit. The stall-active status bit reports when the stall has actually taken effect, one cycle after the walker reports that it is idle.

A page fault records the faulting address, the requester id and the access direction, and then freezes. Later faults leave the record untouched until a hard reset. Two interrupt sources are kept as pending bits, qualified by a mask, and acknowledged by writing ones.

Top module: `mmu_ctrl_regs`

## Requirements

- R1: Word offset 0 holds the directory base. A write keeps bits 31:12 and forces bits 11:0 to zero, so writing 0xCAFEBABE reads back as 0xCAFEB000.
- R2: Writing command value 6 to offset 2 is a hard reset. From the next cycle, the directory base, the paging bit, the stall request and the stall-active bit all read zero. So do the pending interrupts, the mask, the fault-active bit, and the captured address, id and direction.
- R3: Command value 1 sets status bit 0 (offset 1) and the `paging_en` output in the cycle after the write.
- R4: Command value 2 raises `stall_req` in the cycle after the write. Status bit 1 rises one cycle after `stall_req` and `walker_idle` are both high, and stays low while `walker_idle` is low. Command value 3 drops `stall_req`, and status bit 1 falls one cycle later.
- R5: Command value 4 drives `zap_pulse` high for exactly the one cycle after the write.
- R6: Pending bit 0 is the page fault and pending bit 1 is the bus error. Offset 4 is the mask, with bits 1:0 writable. Offset 5 reads pending AND mask. `irq` is the OR of those masked bits.
- R7: Writing ones to offset 6 clears the matching pending bits. If a source event arrives in the same cycle as its clear, the event wins and the bit stays pending.
- R8: A `fault_valid` pulse while no fault is active does four things: it captures `fault_addr` at offset 3, sets status bit 2 and `fault_hold`, places the direction in status bit 3 (1 = write) and the id in status bits 12:8, and sets pending bit 0. While a fault is active, further faults change none of this until a hard reset.
- R9: Command values other than 1, 2, 3, 4 and 6 change no state.
- R10: After the reset input, every readable register, `irq`, `stall_req`, `zap_pulse`, `paging_en` and `fault_hold` are zero. The command and clear offsets read as zero.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| walker_idle | input | 1 | Walker has no outstanding transactions |
| fault_valid | input | 1 | Walker reports a translation fault this cycle |
| fault_addr | input | 32 | Faulting virtual address |
| fault_bus_id | input | 5 | Id of the requester that faulted |
| fault_is_write | input | 1 | Faulting access was a write |
| bus_error | input | 1 | Walker saw a read bus error this cycle |
| paging_en | output | 1 | Translation enabled |
| stall_req | output | 1 | Request for the walker to stall |
| zap_pulse | output | 1 | One-cycle flush of all cached translations |
| fault_hold | output | 1 | Translation frozen by an active fault |
| irq | output | 1 | Interrupt request |

## Verification

A write-one-to-clear acknowledge and a new event from the same source can land on the same clock edge. The bench provokes this by driving a clear of the bus-error bit and a `bus_error` pulse in one cycle, and it expects the bit to remain pending and `irq` to stay high. A second collision pits the hard-reset command against an active fault. There the reset must win, and a fault that arrives afterwards is captured fresh.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;

    localparam int REG_AW     = 3;
    localparam int DATA_W     = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int BUS_ID_W   = 5;
    localparam int N_SRC      = 2;

    // interrupt source positions
    localparam int SRC_FAULT  = 0;
    localparam int SRC_BUSERR = 1;

    // status bit positions
    localparam int ST_PAGING  = 0;
    localparam int ST_STALL   = 1;
    localparam int ST_FAULT   = 2;
    localparam int ST_WRITE   = 3;
    localparam int ST_ID_LSB  = 8;

    typedef enum logic [REG_AW-1:0] {
        OFS_DIR   = 3'd0,
        OFS_STAT  = 3'd1,
        OFS_CMD   = 3'd2,
        OFS_FADDR = 3'd3,
        OFS_MASK  = 3'd4,
        OFS_ISTAT = 3'd5,
        OFS_ICLR  = 3'd6
    } reg_ofs_e;

    localparam logic [DATA_W-1:0] CMD_PAGE_ON   = 32'd1;
    localparam logic [DATA_W-1:0] CMD_STALL_ON  = 32'd2;
    localparam logic [DATA_W-1:0] CMD_STALL_OFF = 32'd3;
    localparam logic [DATA_W-1:0] CMD_ZAP       = 32'd4;
    localparam logic [DATA_W-1:0] CMD_HARD_RST  = 32'd6;

    typedef struct packed {
        logic page_on;
        logic stall_on;
        logic stall_off;
        logic zap;
        logic hard_rst;
    } cmd_t;

    function automatic logic [DATA_W-1:0] dir_trim(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] m;
        m = {DATA_W{1'b1}} << PAGE_SHIFT;
        return v & m;
    endfunction

    function automatic cmd_t decode_cmd(input logic [DATA_W-1:0] v);
        cmd_t c;
        c.page_on   = (v == CMD_PAGE_ON);
        c.stall_on  = (v == CMD_STALL_ON);
        c.stall_off = (v == CMD_STALL_OFF);
        c.zap       = (v == CMD_ZAP);
        c.hard_rst  = (v == CMD_HARD_RST);
        return c;
    endfunction

endpackage

// File: rtl/mmu_cmd_decode.sv
module mmu_cmd_decode
    import mmu_regs_pkg::*;
(
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output cmd_t              cmd
);
    cmd_t raw;

    always_comb begin
        raw = decode_cmd(wdata);
        cmd = wr_en ? raw : '0;
    end
endmodule

// File: rtl/mmu_stall_ctrl.sv
module mmu_stall_ctrl
    import mmu_regs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_t cmd,
    input  logic walker_idle,
    output logic stall_req,
    output logic stall_active
);
    always_ff @(posedge clk) begin
        if (rst || cmd.hard_rst) begin
            stall_req    <= 1'b0;
            stall_active <= 1'b0;
        end else begin
            if (cmd.stall_on)
                stall_req <= 1'b1;
            else if (cmd.stall_off)
                stall_req <= 1'b0;
            // takes effect once the walker has drained
            stall_active <= stall_req && walker_idle;
        end
    end
endmodule

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture
    import mmu_regs_pkg::*;
#(
    parameter int ID_W = BUS_ID_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              fault_valid,
    input  logic [DATA_W-1:0] fault_addr,
    input  logic [ID_W-1:0]   fault_id,
    input  logic              fault_is_write,
    output logic              active,
    output logic [DATA_W-1:0] addr_q,
    output logic [ID_W-1:0]   id_q,
    output logic              write_q,
    output logic              capture
);
    assign capture = fault_valid && !active && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            active  <= 1'b0;
            addr_q  <= '0;
            id_q    <= '0;
            write_q <= 1'b0;
        end else if (capture) begin
            active  <= 1'b1;
            addr_q  <= fault_addr;
            id_q    <= fault_id;
            write_q <= fault_is_write;
        end
    end
endmodule

// File: rtl/mmu_irq_unit.sv
module mmu_irq_unit
    import mmu_regs_pkg::*;
#(
    parameter int N = N_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_all,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wdata,
    input  logic         ack_we,
    input  logic [N-1:0] ack_bits,
    input  logic [N-1:0] set_bits,
    output logic [N-1:0] mask_q,
    output logic [N-1:0] pend_q,
    output logic [N-1:0] masked,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst || clr_all) begin
                pend_q[i] <= 1'b0;
                mask_q[i] <= 1'b0;
            end else begin
                if (set_bits[i])
                    pend_q[i] <= 1'b1;
                else if (ack_we && ack_bits[i])
                    pend_q[i] <= 1'b0;
                if (mask_we)
                    mask_q[i] <= mask_wdata[i];
            end
        end
    end

    assign masked = pend_q & mask_q;
    assign irq    = |masked;
endmodule

// File: rtl/mmu_ctrl_regs.sv
module mmu_ctrl_regs
    import mmu_regs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_we,
    input  logic [REG_AW-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                walker_idle,
    input  logic                fault_valid,
    input  logic [DATA_W-1:0]   fault_addr,
    input  logic [BUS_ID_W-1:0] fault_bus_id,
    input  logic                fault_is_write,
    input  logic                bus_error,
    output logic                paging_en,
    output logic                stall_req,
    output logic                zap_pulse,
    output logic                fault_hold,
    output logic                irq
);
    logic                dir_we, cmd_we, mask_we, ack_we;
    logic [DATA_W-1:0]   dir_q;
    logic                paging_q;
    logic                zap_q;
    logic                stall_active;
    cmd_t                cmd;
    logic                fault_active, fault_write_q, fault_capture;
    logic [DATA_W-1:0]   fault_addr_q;
    logic [BUS_ID_W-1:0] fault_id_q;
    logic [N_SRC-1:0]    mask_q, pend_q, masked, set_bits;
    logic [DATA_W-1:0]   status_w;

    assign dir_we  = bus_we && (bus_addr == OFS_DIR);
    assign cmd_we  = bus_we && (bus_addr == OFS_CMD);
    assign mask_we = bus_we && (bus_addr == OFS_MASK);
    assign ack_we  = bus_we && (bus_addr == OFS_ICLR);

    mmu_cmd_decode u_dec (
        .wr_en (cmd_we),
        .wdata (bus_wdata),
        .cmd   (cmd)
    );

    mmu_stall_ctrl u_stall (
        .clk          (clk),
        .rst          (rst),
        .cmd          (cmd),
        .walker_idle  (walker_idle),
        .stall_req    (stall_req),
        .stall_active (stall_active)
    );

    mmu_fault_capture #(.ID_W(BUS_ID_W)) u_fault (
        .clk            (clk),
        .rst            (rst),
        .clr            (cmd.hard_rst),
        .fault_valid    (fault_valid),
        .fault_addr     (fault_addr),
        .fault_id       (fault_bus_id),
        .fault_is_write (fault_is_write),
        .active         (fault_active),
        .addr_q         (fault_addr_q),
        .id_q           (fault_id_q),
        .write_q        (fault_write_q),
        .capture        (fault_capture)
    );

    always_comb begin
        set_bits             = '0;
        set_bits[SRC_FAULT]  = fault_capture;
        set_bits[SRC_BUSERR] = bus_error;
    end

    mmu_irq_unit #(.N(N_SRC)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .clr_all    (cmd.hard_rst),
        .mask_we    (mask_we),
        .mask_wdata (bus_wdata[N_SRC-1:0]),
        .ack_we     (ack_we),
        .ack_bits   (bus_wdata[N_SRC-1:0]),
        .set_bits   (set_bits),
        .mask_q     (mask_q),
        .pend_q     (pend_q),
        .masked     (masked),
        .irq        (irq)
    );

    always_ff @(posedge clk) begin
        if (rst || cmd.hard_rst) begin
            dir_q    <= '0;
            paging_q <= 1'b0;
            zap_q    <= 1'b0;
        end else begin
            if (dir_we)
                dir_q <= dir_trim(bus_wdata);
            if (cmd.page_on)
                paging_q <= 1'b1;
            zap_q <= cmd.zap;
        end
    end

    always_comb begin
        status_w                               = '0;
        status_w[ST_PAGING]                    = paging_q;
        status_w[ST_STALL]                     = stall_active;
        status_w[ST_FAULT]                     = fault_active;
        status_w[ST_WRITE]                     = fault_write_q;
        status_w[ST_ID_LSB +: BUS_ID_W]        = fault_id_q;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_DIR:   bus_rdata = dir_q;
            OFS_STAT:  bus_rdata = status_w;
            OFS_FADDR: bus_rdata = fault_addr_q;
            OFS_MASK:  bus_rdata[N_SRC-1:0] = mask_q;
            OFS_ISTAT: bus_rdata[N_SRC-1:0] = masked;
            default:   bus_rdata = '0;
        endcase
    end

    assign paging_en  = paging_q;
    assign zap_pulse  = zap_q;
    assign fault_hold = fault_active;
endmodule

// File: rtl/mmu_ctrl_regs_chk.sv
module mmu_ctrl_regs_chk
    import mmu_regs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              hard,
    input logic              page_on,
    input logic [DATA_W-1:0] dir_q,
    input logic              paging_q,
    input logic              stall_req,
    input logic              stall_active,
    input logic              walker_idle,
    input logic              zap_pulse,
    input logic              fault_active,
    input logic [DATA_W-1:0] fault_addr_q,
    input logic [N_SRC-1:0]  mask_q,
    input logic              irq
);
    p_dir_low_zero_r1: assert property (@(posedge clk) disable iff (rst)
        dir_q[PAGE_SHIFT-1:0] == '0);

    p_hard_clears_r2: assert property (@(posedge clk) disable iff (rst)
        hard |=> (dir_q == '0) && !paging_q && !stall_req && !stall_active
                 && !fault_active && (mask_q == '0));

    p_paging_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(paging_q) |-> $past(page_on));

    p_stall_rise_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(stall_active) |-> $past(stall_req && walker_idle));

    p_zap_single_r5: assert property (@(posedge clk) disable iff (rst)
        zap_pulse |=> !zap_pulse);

    p_irq_masked_r6: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq);

    p_fault_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (fault_active && !hard) |=> fault_active && $stable(fault_addr_q));
endmodule

bind mmu_ctrl_regs mmu_ctrl_regs_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .hard         (cmd.hard_rst),
    .page_on      (cmd.page_on),
    .dir_q        (dir_q),
    .paging_q     (paging_en),
    .stall_req    (stall_req),
    .stall_active (stall_active),
    .walker_idle  (walker_idle),
    .zap_pulse    (zap_pulse),
    .fault_active (fault_hold),
    .fault_addr_q (fault_addr_q),
    .mask_q       (mask_q),
    .irq          (irq)
);

// File: tb/sim_mmu_ctrl_regs.sv
`timescale 1ns/1ps
module sim_mmu_ctrl_regs;
    import mmu_regs_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        walker_idle = 1'b0;
    logic        fault_valid = 1'b0;
    logic [31:0] fault_addr = '0;
    logic [4:0]  fault_bus_id = '0;
    logic        fault_is_write = 1'b0;
    logic        bus_error = 1'b0;
    logic        paging_en, stall_req, zap_pulse, fault_hold, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mmu_ctrl_regs u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .walker_idle(walker_idle),
        .fault_valid(fault_valid), .fault_addr(fault_addr),
        .fault_bus_id(fault_bus_id), .fault_is_write(fault_is_write),
        .bus_error(bus_error), .paging_en(paging_en), .stall_req(stall_req),
        .zap_pulse(zap_pulse), .fault_hold(fault_hold), .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic [2:0]  a;
        logic [31:0] d;
        logic [31:0] e;
        logic [3:0]  r;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b1, 3'd0, 32'hCAFEBABE, 32'h0, 4'd1},   // R1
        '{1'b0, 3'd0, 32'h0, 32'hCAFEB000, 4'd1},   // R1
        '{1'b1, 3'd0, 32'hFFFFFFFF, 32'h0, 4'd1},
        '{1'b0, 3'd0, 32'h0, 32'hFFFFF000, 4'd1},
        '{1'b1, 3'd4, 32'hFFFFFFFF, 32'h0, 4'd6},   // R6 mask width
        '{1'b0, 3'd4, 32'h0, 32'h00000003, 4'd6},
        '{1'b1, 3'd2, 32'h00000001, 32'h0, 4'd3},   // R3 paging on
        '{1'b0, 3'd1, 32'h0, 32'h00000001, 4'd3},
        '{1'b1, 3'd2, 32'h00000007, 32'h0, 4'd9},   // R9 undefined code
        '{1'b1, 3'd2, 32'h00000005, 32'h0, 4'd9},
        '{1'b0, 3'd1, 32'h0, 32'h00000001, 4'd9},
        '{1'b0, 3'd0, 32'h0, 32'hFFFFF000, 4'd9},
        '{1'b1, 3'd2, 32'h00000006, 32'h0, 4'd2},   // R2 hard reset
        '{1'b0, 3'd0, 32'h0, 32'h00000000, 4'd2},
        '{1'b0, 3'd1, 32'h0, 32'h00000000, 4'd2},
        '{1'b0, 3'd4, 32'h0, 32'h00000000, 4'd2}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
        #0.5;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic inject_fault(input logic [31:0] a, input logic [4:0] id, input logic w);
        @(negedge clk);
        fault_valid = 1'b1; fault_addr = a; fault_bus_id = id; fault_is_write = w;
        @(negedge clk);
        fault_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        for (int a = 0; a < 8; a++) begin
            bus_read(3'(a), rd);
            chk("R10 register after reset", rd, 32'h0);
        end
        chk("R10 outputs after reset",
            {27'h0, irq, stall_req, zap_pulse, paging_en, fault_hold}, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                bus_write(VEC[i].a, VEC[i].d);
            end else begin
                bus_read(VEC[i].a, rd);
                chk($sformatf("R%0d table entry %0d", VEC[i].r, i), rd, VEC[i].e);
            end
        end
        chk("R2 paging_en after hard reset", {31'h0, paging_en}, 32'h0);

        // R4 stall handshake
        walker_idle = 1'b0;
        bus_write(3'd2, 32'd2);
        chk("R4 stall_req raised", {31'h0, stall_req}, 32'h1);
        bus_read(3'd1, rd);
        chk("R4 stall bit low while walker busy", rd, 32'h0);
        bus_read(3'd1, rd);
        chk("R4 stall bit still low", rd, 32'h0);
        walker_idle = 1'b1;
        bus_read(3'd1, rd);
        chk("R4 stall bit one cycle after idle", rd, 32'h2);
        bus_write(3'd2, 32'd3);
        chk("R4 stall_req dropped", {31'h0, stall_req}, 32'h0);
        bus_read(3'd1, rd);
        chk("R4 stall bit fallen", rd, 32'h0);

        // R5 flush strobe
        bus_write(3'd2, 32'd4);
        chk("R5 zap_pulse high after write", {31'h0, zap_pulse}, 32'h1);
        @(negedge clk); #0.5;
        chk("R5 zap_pulse single cycle", {31'h0, zap_pulse}, 32'h0);

        // R8 fault capture, R6 masking
        inject_fault(32'h12345678, 5'h13, 1'b1);
        bus_read(3'd1, rd);
        chk("R8 status after fault", rd, 32'h0000130C);
        bus_read(3'd3, rd);
        chk("R8 captured address", rd, 32'h12345678);
        chk("R8 fault_hold", {31'h0, fault_hold}, 32'h1);
        bus_read(3'd5, rd);
        chk("R6 masked status with mask zero", rd, 32'h0);
        chk("R6 irq with mask zero", {31'h0, irq}, 32'h0);
        inject_fault(32'hAAAA0000, 5'h02, 1'b0);
        bus_read(3'd3, rd);
        chk("R8 second fault ignored addr", rd, 32'h12345678);
        bus_read(3'd1, rd);
        chk("R8 second fault ignored status", rd, 32'h0000130C);
        bus_write(3'd4, 32'h1);
        bus_read(3'd5, rd);
        chk("R6 masked status fault", rd, 32'h1);
        chk("R6 irq raised", {31'h0, irq}, 32'h1);

        // R6 bus error masked off, then unmasked
        @(negedge clk); bus_error = 1'b1;
        @(negedge clk); bus_error = 1'b0;
        bus_read(3'd5, rd);
        chk("R6 bus error masked", rd, 32'h1);
        bus_write(3'd4, 32'h3);
        bus_read(3'd5, rd);
        chk("R6 both sources visible", rd, 32'h3);

        // R7 clear and new event in the same cycle
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'd6; bus_wdata = 32'h2; bus_error = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0; bus_error = 1'b0;
        bus_read(3'd5, rd);
        chk("R7 event wins over clear", rd, 32'h3);
        bus_write(3'd6, 32'h2);
        bus_read(3'd5, rd);
        chk("R7 clear bus error", rd, 32'h1);
        bus_write(3'd6, 32'h1);
        bus_read(3'd5, rd);
        chk("R7 clear fault", rd, 32'h0);
        chk("R7 irq dropped", {31'h0, irq}, 32'h0);

        // R2 hard reset releases fault; fresh capture follows
        bus_write(3'd2, 32'd6);
        bus_read(3'd1, rd);
        chk("R2 status cleared", rd, 32'h0);
        bus_read(3'd3, rd);
        chk("R2 fault address cleared", rd, 32'h0);
        bus_read(3'd4, rd);
        chk("R2 mask cleared", rd, 32'h0);
        chk("R2 fault_hold cleared", {31'h0, fault_hold}, 32'h0);
        inject_fault(32'h0BAD0000, 5'h07, 1'b0);
        bus_read(3'd3, rd);
        chk("R8 capture after hard reset", rd, 32'h0BAD0000);
        bus_read(3'd1, rd);
        chk("R8 read direction and id", rd, 32'h00000704);

        finish_run();
    end
endmodule